// File: doc/BRIEF.md
# Word-Serial Signed-Magnitude Adder/Subtractor

This block adds and subtracts long operands one word per cycle using only an unsigned adder. Subtraction is done by inverting the second operand and seeding the carry with one. The magnitudes travel through the block as a stream of words, least significant word first. The sign of each value lives in a small file of five sign bits, named A, B, C, D and S.

When the last word of an operation is accepted, the block updates the signs from fixed boolean rules. Each rule uses only the old signs, the final carry-out J of the unsigned chain and, for the combining step, a mode bit P. No signed adder is involved. The same completion edge also records:
- the carry J;
- the bit pushed out by a one-place left shift;
- the parity of the result.

Input words and result words use valid/ready handshakes. A result word is held unchanged while the consumer withholds `out_ready`. `in_ready` is high whenever the single output slot is empty or is being drained in the same cycle. The operation code and P are captured from the first word of each operation. An external sequencer can overwrite the whole sign file through a plain write port.

Top module: `signmag_addsub`

## Requirements
- R1: After reset, `sign_o`, `carry_o`, `shout_o`, `parity_o`, `out_valid` and `done` are all 0.
- R2: Each accepted input word produces exactly one output word, in order, one cycle later. `out_last` is 1 on word NWORDS-1 of each operation. While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_z` and `out_last` hold steady. `in_ready` = !out_valid || out_ready.
- R3: Code 0 (add): the result words form X+Y over NWORDS*W bits with carry-in 0. J, the final carry-out, is stored in `carry_o`.
- R4: Code 1 (subtract): the result is X + ~Y + 1 over the full width. J is stored in `carry_o`, and J=1 exactly when X>=Y. X=Y gives all-zero words with J=1.
- R5: Codes 2 to 5 subtract as in R4 and then update one sign. Code 2: A <= A & ~J. Code 3: B <= B | ~J. Code 4: C <= C & ~J. Code 5: D <= D | ~J. Sign bit positions are A=0, B=1, C=2, D=3, S=4. A sign of 1 means negative.
- R6: Code 6 (combine) adds when P=1 and subtracts when P=0. It then sets S <= ~(J|P) | (A & P).
- R7: Code 7 shifts X left by one place across all words. Y is ignored, bit 0 of the result is 0, and the top bit of X goes to `shout_o`. `carry_o` is left unchanged.
- R8: At completion, `parity_o` takes bit 0 of result word 0.
- R9: `done` is a one-cycle pulse, high in the cycle after the last word is accepted, while that word is in the output slot. Signs, `carry_o`, `shout_o` and `parity_o` change only at that point, or through R10.
- R10: `sgn_wr_en` loads `sgn_wr_data` into all five signs on the next clock edge. It takes priority over a completion update on the same edge.
- R11: `in_op` and `in_p` are sampled only with word 0 of an operation. Their values on later words have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block can take an input word |
| in_x | input | W | First operand word |
| in_y | input | W | Second operand word |
| in_op | input | 3 | Operation code (sampled on word 0) |
| in_p | input | 1 | Combine mode P (sampled on word 0) |
| out_valid | output | 1 | Result word valid |
| out_ready | input | 1 | Consumer takes the result word |
| out_z | output | W | Result word |
| out_last | output | 1 | Result word is the last of its operation |
| done | output | 1 | Completion pulse |
| sgn_wr_en | input | 1 | Load sign file |
| sgn_wr_data | input | 5 | Sign values to load |
| sign_o | output | 5 | Signs A,B,C,D,S (bits 0..4) |
| carry_o | output | 1 | Last arithmetic carry J |
| shout_o | output | 1 | Bit shifted out by the last shift |
| parity_o | output | 1 | Bit 0 of the last result |

## Verification
The assertions assume the sign file changes only at a completion pulse or one cycle after a `sgn_wr_en` write. They also assume a write never lands on the same edge as a completion, because only then does each sign's one-way rule (A and C can only clear, B and D can only set) hold visibly at the ports. The stimulus issues every sign write only after the previous operation's pulse has passed, and before the next operation starts. Operand words carry deliberately wrong codes on every word after the first, and `out_ready` is toggled at random in a back-pressure phase. Stalls and code changes are therefore present in the stimulus, but they are not assumed by the assertions.

// File: rtl/smadd_pkg.sv
package smadd_pkg;
  localparam int SGN_N = 5;
  localparam int SG_A = 0;
  localparam int SG_B = 1;
  localparam int SG_C = 2;
  localparam int SG_D = 3;
  localparam int SG_S = 4;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_SUBA = 3'd2,
    OP_SUBB = 3'd3,
    OP_SUBC = 3'd4,
    OP_SUBD = 3'd5,
    OP_COMB = 3'd6,
    OP_SHL  = 3'd7
  } op_t;

  function automatic logic op_subtracts(op_t op, logic p);
    case (op)
      OP_SUB, OP_SUBA, OP_SUBB, OP_SUBC, OP_SUBD: op_subtracts = 1'b1;
      OP_COMB: op_subtracts = ~p;
      default: op_subtracts = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/smadd_word_alu.sv
module smadd_word_alu #(
  parameter int W = 64
) (
  input  logic         sub,
  input  logic         shl,
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] z,
  output logic         cout
);
  logic [W:0]   sum;
  logic [W-1:0] y_eff;

  always_comb begin
    // two's-complement subtraction: invert here, the +1 arrives as carry-in
    y_eff = sub ? ~y : y;
    sum   = {1'b0, x} + {1'b0, y_eff} + {{W{1'b0}}, cin};
    if (shl) begin
      z    = {x[W-2:0], cin};
      cout = x[W-1];
    end else begin
      z    = sum[W-1:0];
      cout = sum[W];
    end
  end
endmodule

// File: rtl/smadd_sign_rules.sv
module smadd_sign_rules
  import smadd_pkg::*;
(
  input  op_t              op,
  input  logic             p,
  input  logic             j,
  input  logic [SGN_N-1:0] cur,
  output logic [SGN_N-1:0] nxt
);
  always_comb begin
    nxt = cur;
    case (op)
      OP_SUBA: nxt[SG_A] = cur[SG_A] & ~j;
      OP_SUBB: nxt[SG_B] = cur[SG_B] | ~j;
      OP_SUBC: nxt[SG_C] = cur[SG_C] & ~j;
      OP_SUBD: nxt[SG_D] = cur[SG_D] | ~j;
      OP_COMB: nxt[SG_S] = ~(j | p) | (cur[SG_A] & p);
      default: nxt = cur;
    endcase
  end
endmodule

// File: rtl/signmag_addsub.sv
module signmag_addsub
  import smadd_pkg::*;
#(
  parameter int W      = 64,
  parameter int NWORDS = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_x,
  input  logic [W-1:0] in_y,
  input  logic [2:0]   in_op,
  input  logic         in_p,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_z,
  output logic         out_last,
  output logic         done,
  input  logic         sgn_wr_en,
  input  logic [4:0]   sgn_wr_data,
  output logic [4:0]   sign_o,
  output logic         carry_o,
  output logic         shout_o,
  output logic         parity_o
);
  localparam int CW = (NWORDS > 1) ? $clog2(NWORDS) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(NWORDS - 1);

  logic [CW-1:0]    cnt_q;
  op_t              op_q;
  logic             p_q;
  logic             cy_q;
  logic             par_q;
  logic [W-1:0]     z_q;
  logic             vld_q, last_q, done_q;
  logic [SGN_N-1:0] sgn_q;
  logic             carry_q, shout_q, parity_q;

  logic             acc, first, last_w, cin, cout, par_e;
  op_t              op_e;
  logic             p_e;
  logic [W-1:0]     z_w;
  logic [SGN_N-1:0] sgn_n;

  assign in_ready = ~vld_q | out_ready;
  assign acc      = in_valid & in_ready;
  assign first    = (cnt_q == '0);
  assign last_w   = (cnt_q == LAST_IDX);
  // code and mode come from word 0; later words reuse the captured copy
  assign op_e     = first ? op_t'(in_op) : op_q;
  assign p_e      = first ? in_p : p_q;
  assign cin      = first ? op_subtracts(op_e, p_e) : cy_q;

  smadd_word_alu #(.W(W)) u_alu (
    .sub  (op_subtracts(op_e, p_e)),
    .shl  (op_e == OP_SHL),
    .x    (in_x),
    .y    (in_y),
    .cin  (cin),
    .z    (z_w),
    .cout (cout)
  );

  assign par_e = first ? z_w[0] : par_q;

  smadd_sign_rules u_rules (
    .op  (op_e),
    .p   (p_e),
    .j   (cout),
    .cur (sgn_q),
    .nxt (sgn_n)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      op_q     <= OP_ADD;
      p_q      <= 1'b0;
      cy_q     <= 1'b0;
      par_q    <= 1'b0;
      z_q      <= '0;
      vld_q    <= 1'b0;
      last_q   <= 1'b0;
      done_q   <= 1'b0;
      sgn_q    <= '0;
      carry_q  <= 1'b0;
      shout_q  <= 1'b0;
      parity_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (vld_q && out_ready) vld_q <= 1'b0;
      if (acc) begin
        z_q    <= z_w;
        last_q <= last_w;
        vld_q  <= 1'b1;
        cy_q   <= cout;
        if (first) begin
          op_q  <= op_e;
          p_q   <= in_p;
          par_q <= z_w[0];
        end
        cnt_q <= last_w ? '0 : cnt_q + CW'(1);
        if (last_w) begin
          done_q   <= 1'b1;
          sgn_q    <= sgn_n;
          parity_q <= par_e;
          if (op_e == OP_SHL) shout_q <= cout;
          else                carry_q <= cout;
        end
      end
      if (sgn_wr_en) sgn_q <= sgn_wr_data;
    end
  end

  assign out_valid = vld_q;
  assign out_z     = z_q;
  assign out_last  = last_q;
  assign done      = done_q;
  assign sign_o    = sgn_q;
  assign carry_o   = carry_q;
  assign shout_o   = shout_q;
  assign parity_o  = parity_q;
endmodule

// File: rtl/signmag_addsub_chk.sv
module signmag_addsub_chk #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_z,
  input logic         out_last,
  input logic         done,
  input logic         sgn_wr_en,
  input logic [4:0]   sign_o,
  input logic         carry_o,
  input logic         shout_o,
  input logic         parity_o
);
  p_stall_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_z) && $stable(out_last));

  p_done_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> out_valid && out_last);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_status_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !($stable(carry_o) && $stable(shout_o) && $stable(parity_o)) |-> done);

  p_sign_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sign_o) |-> done || $past(sgn_wr_en));

  p_a_clear_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done && !$past(sgn_wr_en) |-> !$rose(sign_o[0]));

  p_b_set_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done && !$past(sgn_wr_en) |-> !$fell(sign_o[1]));

  p_c_clear_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done && !$past(sgn_wr_en) |-> !$rose(sign_o[2]));

  p_d_set_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done && !$past(sgn_wr_en) |-> !$fell(sign_o[3]));
endmodule

bind signmag_addsub signmag_addsub_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_z     (out_z),
  .out_last  (out_last),
  .done      (done),
  .sgn_wr_en (sgn_wr_en),
  .sign_o    (sign_o),
  .carry_o   (carry_o),
  .shout_o   (shout_o),
  .parity_o  (parity_o)
);

// File: tb/signmag_addsub_test.sv
module signmag_addsub_test;
  localparam int W  = 16;
  localparam int N  = 4;
  localparam int TW = W * N;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready, in_p = 1'b0;
  logic [W-1:0] in_x = '0, in_y = '0, out_z;
  logic [2:0] in_op = '0;
  logic out_valid, out_ready = 1'b1, out_last, done;
  logic sgn_wr_en = 1'b0;
  logic [4:0] sgn_wr_data = '0, sign_o;
  logic carry_o, shout_o, parity_o;

  signmag_addsub #(.W(W), .NWORDS(N)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_x(in_x), .in_y(in_y), .in_op(in_op), .in_p(in_p),
    .out_valid(out_valid), .out_ready(out_ready), .out_z(out_z),
    .out_last(out_last), .done(done), .sgn_wr_en(sgn_wr_en),
    .sgn_wr_data(sgn_wr_data), .sign_o(sign_o), .carry_o(carry_o),
    .shout_o(shout_o), .parity_o(parity_o)
  );

  always #10 clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;
  bit stall_mode = 0;

  logic [W-1:0] q_word[$];
  bit           q_last[$];
  int           q_wop[$];
  int           s_op[$];
  bit           s_p[$], s_j[$], s_sh[$], s_par[$];

  logic [4:0] m_sgn = '0;
  bit m_carry = 0, m_shout = 0, m_par = 0;
  bit prev_stall = 0;
  logic [W-1:0] prev_z;
  bit prev_last;

  function automatic string tag_of(int op);
    case (op)
      0: return "R3";
      1: return "R4";
      6: return "R6";
      7: return "R7";
      default: return "R5";
    endcase
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference: compute full-width result, queue words and completion status
  task automatic run_op(int op, bit p, logic [TW-1:0] x, logic [TW-1:0] y);
    logic [TW:0] r;
    bit sub;
    sub = (op >= 1 && op <= 5) || (op == 6 && !p);
    if (op == 7) r = {x, 1'b0};
    else if (sub) r = {1'b0, x} + {1'b0, ~y} + 1;
    else r = {1'b0, x} + {1'b0, y};
    for (int w = 0; w < N; w++) begin
      q_word.push_back(r[w*W +: W]);
      q_last.push_back(w == N - 1);
      q_wop.push_back(op);
    end
    s_op.push_back(op); s_p.push_back(p);
    s_j.push_back(r[TW]); s_sh.push_back(x[TW-1]); s_par.push_back(r[0]);
    for (int w = 0; w < N; w++) begin
      in_valid = 1'b1;
      in_x = x[w*W +: W];
      in_y = y[w*W +: W];
      // R11: later words carry a different code and mode
      in_op = (w == 0) ? 3'(op) : ~3'(op);
      in_p  = (w == 0) ? p : ~p;
      forever begin
        @(negedge clk);
        if (in_ready) break;
      end
      @(posedge clk); #2;
    end
    in_valid = 1'b0;
  endtask

  task automatic write_signs(logic [4:0] d);
    @(posedge clk); #2;
    sgn_wr_en = 1'b1; sgn_wr_data = d;
    @(posedge clk); #2;
    sgn_wr_en = 1'b0;
  endtask

  always @(posedge clk) begin
    #1 out_ready = stall_mode ? 1'($urandom % 2) : 1'b1;
  end

  // per-clock comparison against the behavioural model
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      if (prev_stall) begin
        check(out_valid && out_z == prev_z && out_last == prev_last, "R2",
              "stalled word held", longint'(out_z), longint'(prev_z));
      end
      if (out_valid && out_ready) begin
        if (q_word.size() == 0) begin
          check(0, "R2", "unexpected output word", longint'(out_z), 0);
        end else begin
          int op;
          op = q_wop.pop_front();
          check(out_z == q_word[0], tag_of(op), "result word",
                longint'(out_z), longint'(q_word[0]));
          check(out_last == q_last[0], "R2", "out_last",
                longint'(out_last), longint'(q_last[0]));
          void'(q_word.pop_front()); void'(q_last.pop_front());
        end
      end
      if (done) begin
        check(out_valid && out_last, "R9", "done with last word", 0, 1);
        if (s_op.size() > 0) begin
          int op; bit p, j;
          op = s_op.pop_front(); p = s_p.pop_front(); j = s_j.pop_front();
          if (op == 7) m_shout = s_sh[0]; else m_carry = j;
          m_par = s_par[0];
          void'(s_sh.pop_front()); void'(s_par.pop_front());
          case (op)
            2: m_sgn[0] = m_sgn[0] & ~j;
            3: m_sgn[1] = m_sgn[1] | ~j;
            4: m_sgn[2] = m_sgn[2] & ~j;
            5: m_sgn[3] = m_sgn[3] | ~j;
            6: m_sgn[4] = ~(j | p) | (m_sgn[0] & p);
            default: ;
          endcase
        end else begin
          check(0, "R9", "done without operation", 1, 0);
        end
      end
      check(sign_o == m_sgn, "R5/R6/R10", "signs", longint'(sign_o), longint'(m_sgn));
      check(carry_o == m_carry, "R3/R4", "carry J", longint'(carry_o), longint'(m_carry));
      check(shout_o == m_shout, "R7", "shift-out", longint'(shout_o), longint'(m_shout));
      check(parity_o == m_par, "R8", "parity", longint'(parity_o), longint'(m_par));
      if (sgn_wr_en) m_sgn = sgn_wr_data; // R10: takes effect at next edge
      prev_stall = out_valid && !out_ready;
      prev_z = out_z; prev_last = out_last;
    end
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: actual=%0d cycles expected=completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state
    check(out_valid == 0 && done == 0, "R1", "stream idle in reset", longint'(out_valid), 0);
    check(sign_o == 0 && carry_o == 0 && shout_o == 0 && parity_o == 0, "R1",
          "status cleared", longint'({sign_o, carry_o, shout_o, parity_o}), 0);
    rst_n = 1'b1;
    @(posedge clk); #2;
    // R3: carry ripples across a word boundary, then wraps to zero
    run_op(0, 0, 64'h0000_0000_0000_FFFF, 64'd1);
    run_op(0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1);
    // R4: larger, smaller and equal magnitudes
    run_op(1, 0, 64'd100, 64'd30);
    run_op(1, 0, 64'd30, 64'h0001_0000_0000_0064);
    run_op(1, 0, 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0);
    // R5: each sign rule with J=0 and J=1
    write_signs(5'b00101);
    run_op(2, 0, 64'd10, 64'd3);
    write_signs(5'b00101);
    run_op(2, 0, 64'd3, 64'd10);
    run_op(4, 0, 64'd3, 64'd10);
    run_op(4, 0, 64'h10000, 64'd7);
    write_signs(5'b00000);
    run_op(3, 0, 64'd9, 64'd9);
    run_op(3, 0, 64'd1, 64'd2);
    run_op(5, 0, 64'd1, 64'd2);
    // R6: combine with both modes
    write_signs(5'b00001);
    run_op(6, 1, 64'd5, 64'd6);
    run_op(6, 0, 64'd5, 64'd6);
    run_op(6, 0, 64'd6, 64'd5);
    write_signs(5'b10000);
    run_op(6, 1, 64'hFFFF, 64'd1);
    // R7: shift with a set top bit and a boundary crossing
    run_op(7, 0, 64'h8000_0000_0000_0001, 64'hFFFF);
    run_op(7, 1, 64'h0000_0000_0000_8000, 64'd0);
    // R2 under back-pressure, mixed operations
    stall_mode = 1;
    for (int k = 0; k < 30; k++) begin
      logic [TW-1:0] a, b;
      a = {32'($urandom), 32'($urandom)};
      b = (k % 5 == 0) ? a : {32'($urandom), 32'($urandom)};
      run_op(int'($urandom % 8), 1'($urandom % 2), a, b);
      if (k % 7 == 3) write_signs(5'($urandom));
    end
    stall_mode = 0;
    repeat (10) @(posedge clk);
    check(q_word.size() == 0 && s_op.size() == 0, "R2", "all results drained",
          longint'(q_word.size()), 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule